// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of hardware debug triggers for one hart. Every cycle it compares the address of the instruction about to retire, and the address of any load or store in flight, against the value programmed in each trigger. A trigger that matches is then qualified by the current privilege level (including the two virtualized levels) and by two optional context checks. The first compares against the process identity (a software context word or the address-space identifier). The second compares against the guest identity (a hypervisor context word or the virtual-machine identifier).

A qualified match is reported before the instruction takes effect. Each trigger carries one action bit. Clear, it asks the core for a breakpoint exception, as a self-hosted debugger wants. Set, it asks for entry into debug mode, as an external debugger wants. The per-trigger hit vector and one combined request leave the block combinationally in the cycle the inputs are presented. Triggers are programmed through a plain indexed write port, and the same register view is read back through a combinational read port.

Top module: `dbg_trigger_bank`

## Requirements
- R1: After reset every trigger reads back zero in all three registers (control, address, context). No hit is reported, even when the PC and memory address equal the reset address value of 0.
- R2: A trigger with execute enable (control bit 0) hits when `retire_valid` is high and `retire_pc` equals its address register exactly. A load or store at that address does not make it hit.
- R3: Store enable is control bit 1 and load enable is control bit 2. All four combinations are legal. A memory hit needs an enabled strobe and `mem_addr` exactly equal to the address register.
- R4: The mode-enable bits are U=bit 3, S=bit 4, M=bit 5, VU=bit 6, VS=bit 7. `cur_priv` 3 is M whatever `cur_virt` is. Priv 1 is S (virt 0) or VS (virt 1), and priv 0 is U or VU. A hit needs the bit of the current mode to be set, and priv 2 never hits.
- R5: The context register holds the process selector in bits [1:0] and the process value in bits [15:8]. Selector 1 passes only when the process value equals `cur_scontext`.
- R6: Process selector 2 passes only when the process value equals `cur_asid`. Selector 0 passes whatever the context.
- R7: The context register holds the guest selector in bits [4:2] and the guest value in bits [20:16]. The guest compare word is {guest value, selector bit 2}. Selectors 1 and 5 pass only when this word equals `cur_hcontext`, and selector 0 always passes.
- R8: Guest selectors 2 and 6 pass only when the same guest compare word equals `cur_vmid`.
- R9: A write of process selector 3 stores 0. A write of guest selector 3, 4 or 7 stores 0. The other context fields are stored as written, and unimplemented bits read 0.
- R10: Control bit 8 is the action bit. When any hitting trigger has action 1, `dbg_req` is high and `brk_exc` is low. Otherwise any hit raises `brk_exc`. The two outputs are never high together.
- R11: A write changes only the addressed register of the addressed trigger and takes effect at the next clock edge. Control reads back its nine implemented bits, and the address register reads back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | IDX_W | Trigger selected for write |
| cfg_wr_sel | input | 2 | Register selected for write: 0 control, 1 address, 2 context |
| cfg_wr_data | input | XLEN | Write data |
| cfg_rd_idx | input | IDX_W | Trigger selected for read |
| cfg_rd_sel | input | 2 | Register selected for read, same encoding as for write |
| cfg_rd_data | output | XLEN | Combinational read data |
| retire_valid | input | 1 | An instruction is about to retire |
| retire_pc | input | XLEN | Address of that instruction |
| mem_ld_valid | input | 1 | A load is in flight |
| mem_st_valid | input | 1 | A store is in flight |
| mem_addr | input | XLEN | Data address of the load or store |
| cur_priv | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Hart runs virtualized |
| cur_scontext | input | SCTX_W | Current process context word |
| cur_asid | input | ASID_W | Current address-space identifier |
| cur_hcontext | input | HCTX_W | Current hypervisor context word |
| cur_vmid | input | VMID_W | Current virtual-machine identifier |
| trig_hit | output | NUM_TRIG | Per-trigger qualified hit |
| brk_exc | output | 1 | Breakpoint exception request |
| dbg_req | output | 1 | Debug-mode entry request |

## Verification
The bench sweeps the selectors, mode bits and strobe combinations against a configuration model it keeps itself. The sharpest corner is the guest compare word. A design that drops selector bit 2 from the low end, or puts it at the top, hits on the wrong guest identity for selectors 5 and 6 and misses on the right one. Exact-equality neighbours four bytes away, the reserved privilege level and M-mode with the virtualization flag set each catch a looser address or mode decode. Overlapping hits with mixed actions expose a combiner that raises both requests or lets the breakpoint win. Writes of the illegal selector codes expose a register that stores them as written and later passes or fails qualifiers at random.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

  // register selector codes for the config port
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_CTX  = 2'd2;

  // context register field placement (low fields fixed, values parameter-sized)
  localparam int SSEL_LSB = 0;
  localparam int HSEL_LSB = 2;
  localparam int SVAL_LSB = 8;

  // control word, MSB first: bit 8 action .. bit 0 execute enable
  typedef struct packed {
    logic action;
    logic vs_en;
    logic vu_en;
    logic m_en;
    logic s_en;
    logic u_en;
    logic ld_en;
    logic st_en;
    logic ex_en;
  } trig_ctrl_t;

  localparam int CTRL_W = $bits(trig_ctrl_t);

  function automatic logic [1:0] legal_ssel(input logic [1:0] v);
    return (v == 2'd3) ? 2'd0 : v;
  endfunction

  function automatic logic [2:0] legal_hsel(input logic [2:0] v);
    logic [2:0] r;
    case (v)
      3'd3, 3'd4, 3'd7: r = 3'd0;
      default:          r = v;
    endcase
    return r;
  endfunction

  // mode filter: M ignores virt, priv 2 is reserved
  function automatic logic mode_allowed(input trig_ctrl_t c, input logic [1:0] priv,
                                        input logic virt);
    logic r;
    case (priv)
      2'd3:    r = c.m_en;
      2'd1:    r = virt ? c.vs_en : c.s_en;
      2'd0:    r = virt ? c.vu_en : c.u_en;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import dbgtrig_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SV_W = 8,
  parameter int MH_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [1:0]       wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  output trig_ctrl_t       ctrl_o,
  output logic [XLEN-1:0]  addr_o,
  output logic [1:0]       ssel_o,
  output logic [SV_W-1:0]  svalue_o,
  output logic [2:0]       hsel_o,
  output logic [MH_W-1:0]  mhvalue_o,
  output logic [XLEN-1:0]  ctx_word_o
);
  localparam int MH_LSB = SVAL_LSB + SV_W;

  trig_ctrl_t      ctrl_q;
  logic [XLEN-1:0] addr_q;
  logic [1:0]      ssel_q;
  logic [SV_W-1:0] sval_q;
  logic [2:0]      hsel_q;
  logic [MH_W-1:0] mhval_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      ssel_q  <= '0;
      sval_q  <= '0;
      hsel_q  <= '0;
      mhval_q <= '0;
    end else if (wr_hit) begin
      case (wr_sel)
        REG_CTRL: ctrl_q <= trig_ctrl_t'(wr_data[CTRL_W-1:0]);
        REG_ADDR: addr_q <= wr_data;
        REG_CTX: begin
          ssel_q  <= legal_ssel(wr_data[SSEL_LSB +: 2]);
          hsel_q  <= legal_hsel(wr_data[HSEL_LSB +: 3]);
          sval_q  <= wr_data[SVAL_LSB +: SV_W];
          mhval_q <= wr_data[MH_LSB +: MH_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctx_word_o = '0;
    ctx_word_o[SSEL_LSB +: 2]    = ssel_q;
    ctx_word_o[HSEL_LSB +: 3]    = hsel_q;
    ctx_word_o[SVAL_LSB +: SV_W] = sval_q;
    ctx_word_o[MH_LSB +: MH_W]   = mhval_q;
  end

  assign ctrl_o    = ctrl_q;
  assign addr_o    = addr_q;
  assign ssel_o    = ssel_q;
  assign svalue_o  = sval_q;
  assign hsel_o    = hsel_q;
  assign mhvalue_o = mhval_q;

  // R9
  ssel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_sel == REG_CTX && wr_data[SSEL_LSB +: 2] == 2'd3) |=> ssel_q == 2'd0);

  // R9
  hsel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_sel == REG_CTX &&
     (wr_data[HSEL_LSB +: 3] == 3'd3 || wr_data[HSEL_LSB +: 3] == 3'd4 ||
      wr_data[HSEL_LSB +: 3] == 3'd7)) |=> hsel_q == 3'd0);

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == '0 && ssel_q == 2'd0 && hsel_q == 3'd0));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit) |=> $stable(ctrl_q) && $stable(addr_q));

endmodule

// File: rtl/trig_match.sv
module trig_match
  import dbgtrig_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SCTX_W = 8,
  parameter int ASID_W = 8,
  parameter int HCTX_W = 6,
  parameter int VMID_W = 6,
  parameter int SV_W = 8,
  parameter int MH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trig_ctrl_t        ctrl_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [1:0]        ssel_i,
  input  logic [SV_W-1:0]   svalue_i,
  input  logic [2:0]        hsel_i,
  input  logic [MH_W-1:0]   mhvalue_i,
  input  logic              retire_valid,
  input  logic [XLEN-1:0]   retire_pc,
  input  logic              ld_valid,
  input  logic              st_valid,
  input  logic [XLEN-1:0]   mem_addr,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic [SCTX_W-1:0] scontext,
  input  logic [ASID_W-1:0] asid,
  input  logic [HCTX_W-1:0] hcontext,
  input  logic [VMID_W-1:0] vmid,
  output logic              hit_o
);
  localparam int HV_W = MH_W + 1;

  logic [SV_W-1:0] sctx_x, asid_x;
  logic [HV_W-1:0] hctx_x, vmid_x, guest_word;

  assign sctx_x = SV_W'(scontext);
  assign asid_x = SV_W'(asid);
  assign hctx_x = HV_W'(hcontext);
  assign vmid_x = HV_W'(vmid);
  // selector top bit supplies the low compare bit
  assign guest_word = {mhvalue_i, hsel_i[2]};

  function automatic logic proc_pass(input logic [1:0] sel, input logic [SV_W-1:0] val,
                                     input logic [SV_W-1:0] sc, input logic [SV_W-1:0] as);
    logic r;
    case (sel)
      2'd1:    r = (val == sc);
      2'd2:    r = (val == as);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic guest_pass(input logic [2:0] sel, input logic [HV_W-1:0] w,
                                      input logic [HV_W-1:0] hc, input logic [HV_W-1:0] vm);
    logic r;
    case (sel)
      3'd1, 3'd5: r = (w == hc);
      3'd2, 3'd6: r = (w == vm);
      default:    r = 1'b1;
    endcase
    return r;
  endfunction

  // named events for the assertions
  logic exec_match, data_match, mode_ok, proc_ok, guest_ok;

  assign exec_match = ctrl_i.ex_en && retire_valid && (retire_pc == addr_i);
  assign data_match = ((ctrl_i.ld_en && ld_valid) || (ctrl_i.st_en && st_valid)) &&
                      (mem_addr == addr_i);
  assign mode_ok    = mode_allowed(ctrl_i, priv, virt);
  assign proc_ok    = proc_pass(ssel_i, svalue_i, sctx_x, asid_x);
  assign guest_ok   = guest_pass(hsel_i, guest_word, hctx_x, vmid_x);

  assign hit_o = (exec_match || data_match) && mode_ok && proc_ok && guest_ok;

  // R2
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (ctrl_i.ex_en || ctrl_i.ld_en || ctrl_i.st_en));

  // R4
  reserved_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd2) |-> !hit_o);

  // R6
  asid_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ssel_i == 2'd2) |-> (svalue_i == asid_x));

  // R8
  vmid_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && (hsel_i == 3'd2 || hsel_i == 3'd6)) |-> (vmid_x[0] == hsel_i[2]));

endmodule

// File: rtl/trig_combine.sv
module trig_combine #(
  parameter int NUM_TRIG = 4
) (
  input  logic [NUM_TRIG-1:0] hit_i,
  input  logic [NUM_TRIG-1:0] action_i,
  output logic                brk_o,
  output logic                dbg_o
);
  logic any_dbg, any_hit;
  assign any_dbg = |(hit_i & action_i);
  assign any_hit = |hit_i;
  // debug entry outranks the breakpoint exception
  assign dbg_o = any_dbg;
  assign brk_o = any_hit && !any_dbg;
endmodule

// File: rtl/dbg_trigger_bank.sv
module dbg_trigger_bank
  import dbgtrig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN = 32,
  parameter int SCTX_W = 8,
  parameter int ASID_W = 8,
  parameter int HCTX_W = 6,
  parameter int VMID_W = 6,
  localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [IDX_W-1:0]    cfg_wr_idx,
  input  logic [1:0]          cfg_wr_sel,
  input  logic [XLEN-1:0]     cfg_wr_data,
  input  logic [IDX_W-1:0]    cfg_rd_idx,
  input  logic [1:0]          cfg_rd_sel,
  output logic [XLEN-1:0]     cfg_rd_data,
  input  logic                retire_valid,
  input  logic [XLEN-1:0]     retire_pc,
  input  logic                mem_ld_valid,
  input  logic                mem_st_valid,
  input  logic [XLEN-1:0]     mem_addr,
  input  logic [1:0]          cur_priv,
  input  logic                cur_virt,
  input  logic [SCTX_W-1:0]   cur_scontext,
  input  logic [ASID_W-1:0]   cur_asid,
  input  logic [HCTX_W-1:0]   cur_hcontext,
  input  logic [VMID_W-1:0]   cur_vmid,
  output logic [NUM_TRIG-1:0] trig_hit,
  output logic                brk_exc,
  output logic                dbg_req
);
  localparam int SV_W = (SCTX_W > ASID_W) ? SCTX_W : ASID_W;
  localparam int HV_W = (HCTX_W > VMID_W) ? HCTX_W : VMID_W;
  localparam int MH_W = HV_W - 1;

  trig_ctrl_t      ctrl_a  [NUM_TRIG];
  logic [XLEN-1:0] addr_a  [NUM_TRIG];
  logic [XLEN-1:0] ctxw_a  [NUM_TRIG];
  logic [NUM_TRIG-1:0] act_vec;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    logic            wr_hit;
    logic [1:0]      ssel;
    logic [SV_W-1:0] sval;
    logic [2:0]      hsel;
    logic [MH_W-1:0] mhval;

    assign wr_hit = cfg_wr_en && (cfg_wr_idx == IDX_W'(g));

    trig_regs #(.XLEN(XLEN), .SV_W(SV_W), .MH_W(MH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_sel(cfg_wr_sel),
      .wr_data(cfg_wr_data), .ctrl_o(ctrl_a[g]), .addr_o(addr_a[g]),
      .ssel_o(ssel), .svalue_o(sval), .hsel_o(hsel), .mhvalue_o(mhval),
      .ctx_word_o(ctxw_a[g])
    );

    trig_match #(.XLEN(XLEN), .SCTX_W(SCTX_W), .ASID_W(ASID_W), .HCTX_W(HCTX_W),
                 .VMID_W(VMID_W), .SV_W(SV_W), .MH_W(MH_W)) u_match (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_a[g]), .addr_i(addr_a[g]),
      .ssel_i(ssel), .svalue_i(sval), .hsel_i(hsel), .mhvalue_i(mhval),
      .retire_valid(retire_valid), .retire_pc(retire_pc),
      .ld_valid(mem_ld_valid), .st_valid(mem_st_valid), .mem_addr(mem_addr),
      .priv(cur_priv), .virt(cur_virt), .scontext(cur_scontext), .asid(cur_asid),
      .hcontext(cur_hcontext), .vmid(cur_vmid), .hit_o(trig_hit[g])
    );

    assign act_vec[g] = ctrl_a[g].action;
  end

  trig_combine #(.NUM_TRIG(NUM_TRIG)) u_combine (
    .hit_i(trig_hit), .action_i(act_vec), .brk_o(brk_exc), .dbg_o(dbg_req)
  );

  always_comb begin
    cfg_rd_data = '0;
    if (32'(cfg_rd_idx) < NUM_TRIG) begin
      case (cfg_rd_sel)
        REG_CTRL: cfg_rd_data = XLEN'(ctrl_a[cfg_rd_idx]);
        REG_ADDR: cfg_rd_data = addr_a[cfg_rd_idx];
        REG_CTX:  cfg_rd_data = ctxw_a[cfg_rd_idx];
        default:  cfg_rd_data = '0;
      endcase
    end
  end

  // R10
  act_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_exc && dbg_req));

  // R10
  hit_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_hit) |-> (brk_exc || dbg_req));

  // R10
  no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit == '0) |-> !(brk_exc || dbg_req));

endmodule

// File: tb/dbg_trigger_bank_tb.sv
module dbg_trigger_bank_tb;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_en = 0;
  logic [1:0]  wr_idx = 0, wr_sel = 0, rd_idx = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        rv = 0, ld = 0, st = 0, vt = 0;
  logic [31:0] pc = 0, ma = 0;
  logic [1:0]  pv = 0;
  logic [7:0]  sc = 0, as = 0;
  logic [5:0]  hc = 0, vm = 0;
  logic [NT-1:0] hit;
  logic        brk, dbg;

  dbg_trigger_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_idx(wr_idx),
    .cfg_wr_sel(wr_sel), .cfg_wr_data(wr_data), .cfg_rd_idx(rd_idx),
    .cfg_rd_sel(rd_sel), .cfg_rd_data(rd_data), .retire_valid(rv),
    .retire_pc(pc), .mem_ld_valid(ld), .mem_st_valid(st), .mem_addr(ma),
    .cur_priv(pv), .cur_virt(vt), .cur_scontext(sc), .cur_asid(as),
    .cur_hcontext(hc), .cur_vmid(vm), .trig_hit(hit), .brk_exc(brk), .dbg_req(dbg)
  );

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] m_ctrl [NT];
  logic [31:0] m_addr [NT];
  logic [31:0] m_ctx  [NT];

  function automatic logic [31:0] legal_ctx(input logic [31:0] w);
    logic [31:0] r;
    r = w & 32'h001F_FF1F;
    if (r[1:0] == 2'd3) r[1:0] = 2'd0;
    if (r[4:2] == 3'd3 || r[4:2] == 3'd4 || r[4:2] == 3'd7) r[4:2] = 3'd0;
    return r;
  endfunction

  function automatic logic exp_hit(input int i);
    logic [31:0] c, x;
    logic mb, a, s_ok, h_ok;
    logic [5:0] gw;
    c = m_ctrl[i];
    x = m_ctx[i];
    if (pv == 2'd3)      mb = c[5];
    else if (pv == 2'd1) mb = vt ? c[7] : c[4];
    else if (pv == 2'd0) mb = vt ? c[6] : c[3];
    else                 mb = 1'b0;
    a = (c[0] && rv && pc == m_addr[i]) ||
        (((c[2] && ld) || (c[1] && st)) && ma == m_addr[i]);
    s_ok = (x[1:0] == 0) || (x[1:0] == 1 && x[15:8] == sc) || (x[1:0] == 2 && x[15:8] == as);
    gw = {x[20:16], x[4]};
    h_ok = (x[4:2] == 0) || ((x[4:2] == 1 || x[4:2] == 5) && gw == hc) ||
           ((x[4:2] == 2 || x[4:2] == 6) && gw == vm);
    return a && mb && s_ok && h_ok;
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'(i); wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (s == 2'd0) m_ctrl[i] = d & 32'h1FF;
    else if (s == 2'd1) m_addr[i] = d;
    else m_ctx[i] = legal_ctx(d);
  endtask

  task automatic rd_chk(input string tag, input int i, input logic [1:0] s);
    logic [31:0] e;
    e = (s == 0) ? m_ctrl[i] : (s == 1) ? m_addr[i] : m_ctx[i];
    @(negedge clk);
    rd_idx = 2'(i); rd_sel = s;
    #1 check_eq(tag, rd_data, e);
  endtask

  task automatic apply(input logic r, input logic [31:0] p, input logic l, input logic s,
                       input logic [31:0] m, input logic [1:0] pr, input logic v);
    @(negedge clk);
    rv = r; pc = p; ld = l; st = s; ma = m; pv = pr; vt = v;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic [NT-1:0] e, acts;
    logic ed, eb;
    for (int i = 0; i < NT; i++) begin
      e[i] = exp_hit(i);
      acts[i] = m_ctrl[i][8];
    end
    ed = |(e & acts);
    eb = (|e) && !ed;
    check_eq({tag, " hit"}, 32'(hit), 32'(e));
    check_eq({tag, " dbg"}, 32'(dbg), 32'(ed));
    check_eq({tag, " brk"}, 32'(brk), 32'(eb));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      m_ctrl[i] = 0; m_addr[i] = 0; m_ctx[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int i = 0; i < NT; i++)
      for (int s = 0; s < 3; s++) rd_chk("R1 readback", i, 2'(s));
    apply(1, 32'h0, 1, 1, 32'h0, 2'd3, 0);
    check_all("R1");

    // R11: register isolation and readback
    for (int i = 0; i < NT; i++) wr(i, 2'd1, 32'hA000_0000 + 32'(i) * 32'h111);
    for (int i = 0; i < NT; i++) rd_chk("R11 addr", i, 2'd1);
    wr(3, 2'd0, 32'hFFFF_FFFF);
    rd_chk("R11 ctrl", 3, 2'd0);
    rd_chk("R11 other ctrl", 2, 2'd0);
    wr(3, 2'd2, 32'hFFFF_FFFF);
    rd_chk("R9 ctx all ones", 3, 2'd2);
    wr(3, 2'd0, 32'h0);
    wr(3, 2'd2, 32'h0);

    // R2: execute address equality
    wr(0, 2'd1, 32'h1000);
    wr(0, 2'd0, 32'h0F9);
    for (int d = -1; d <= 1; d++)
      for (int r = 0; r < 2; r++) begin
        apply(r[0], 32'h1000 + 32'(d * 4), 0, 0, 0, 2'd3, 0);
        check_all("R2");
      end
    apply(0, 0, 1, 1, 32'h1000, 2'd3, 0);
    check_all("R2 data-side ignored");

    // R3: load/store enable combinations
    wr(1, 2'd1, 32'h2000);
    for (int en = 0; en < 4; en++) begin
      wr(1, 2'd0, 32'h0F8 | (32'(en) << 1));
      for (int s = 0; s < 4; s++) begin
        apply(0, 0, s[1], s[0], 32'h2000, 2'd1, 0);
        check_all("R3");
        apply(0, 0, s[1], s[0], 32'h2004, 2'd1, 0);
        check_all("R3 miss");
      end
    end
    wr(1, 2'd0, 32'h0);

    // R4: mode filter
    for (int m = 3; m <= 7; m++) begin
      wr(0, 2'd0, 32'h1 | (32'h1 << m));
      for (int pvv = 0; pvv < 4; pvv++)
        for (int v = 0; v < 2; v++) begin
          apply(1, 32'h1000, 0, 0, 0, 2'(pvv), v[0]);
          check_all("R4");
        end
    end
    wr(0, 2'd0, 32'h0);

    // R5/R6: process qualifier
    wr(2, 2'd1, 32'h3000);
    wr(2, 2'd0, 32'h0F9);
    for (int ss = 0; ss < 4; ss++) begin
      wr(2, 2'd2, 32'(ss) | 32'h5A00);
      rd_chk("R9 ssel", 2, 2'd2);
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          sc = a[0] ? 8'h5B : 8'h5A;
          as = b[0] ? 8'h11 : 8'h5A;
          apply(1, 32'h3000, 0, 0, 0, 2'd0, 0);
          check_all(ss == 1 ? "R5" : "R6");
        end
    end

    // R7/R8: guest qualifier with selector bit 2 as compare LSB
    for (int hs = 0; hs < 8; hs++) begin
      wr(2, 2'd2, (32'(hs) << 2) | (32'h0B << 16));
      rd_chk("R9 hsel", 2, 2'd2);
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) begin
          hc = (a == 0) ? 6'h16 : (a == 1) ? 6'h17 : 6'h00;
          vm = (b == 0) ? 6'h16 : (b == 1) ? 6'h17 : 6'h00;
          apply(1, 32'h3000, 0, 0, 0, 2'd1, 1);
          check_all((hs == 2 || hs == 6) ? "R8" : "R7");
        end
    end
    wr(2, 2'd0, 32'h0);
    wr(2, 2'd2, 32'h0);

    // R10: action and priority
    wr(0, 2'd0, 32'h0F9);
    wr(1, 2'd1, 32'h1004);
    wr(1, 2'd0, 32'h1F9);
    apply(1, 32'h1000, 0, 0, 0, 2'd3, 0);
    check_all("R10 breakpoint");
    apply(1, 32'h1004, 0, 0, 0, 2'd3, 0);
    check_all("R10 debug");
    wr(1, 2'd1, 32'h1000);
    apply(1, 32'h1000, 0, 0, 0, 2'd3, 0);
    check_all("R10 both");
    check_eq("R10 priority dbg", 32'(dbg), 32'd1);
    check_eq("R10 priority brk", 32'(brk), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule